// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels. Each channel has a 16-bit count made of a low byte and a high byte. A channel advances either once per machine cycle or once per falling edge seen on its event pin. A built-in divider derives the machine cycle from the clock, with a default of one machine cycle per twelve clocks. Each channel selects one of four modes: a 13-bit count (the high byte plus the low five bits of the low byte), a full 16-bit count, an 8-bit count that reloads from the high byte, or a split mode. The split mode exists only on channel 0. It turns that channel into two independent 8-bit counters, and its high half borrows channel 1's run bit and flag.

Software reaches the block through a small register port. The same port writes the count bytes, the control bits and the mode fields, and reads them back. Each channel has a sticky overflow flag, and that flag drives an interrupt request line. A clear-pulse input lets an interrupt controller drop the flag when it acknowledges the request. Channel 1 also produces a one-clock strobe on each of its overflows, which can serve as a baud-rate clock. While channel 0 is split, this strobe is channel 1's only overflow indication.

Top module: `dual_timer_counter`

## Requirements
- R1: After a synchronous reset, every register reads 0x00, `irq_req` is 0 and `baud_strobe` is 0.
- R2: In timer function, a running channel counts up by exactly one per machine cycle, that is, once every `MC_DIV` clocks.
- R3: Mode 0 (mode field 2'd0) counts 13 bits. Bits [4:0] of the low byte carry into the high byte, and bits [7:5] of the low byte never change. Going from high byte 0xFF with low bits 0x1F wraps the 13 bits to zero and sets the flag.
- R4: Mode 1 (mode field 2'd1) counts 16 bits with the low byte below the high byte. Going from 0xFFFF wraps to 0x0000 and sets the flag.
- R5: Mode 2 (mode field 2'd2) counts the low byte only. When the low byte steps from 0xFF, it loads the current high byte value and sets the flag.
- R6: Mode 3 (mode field 2'd3) on channel 0 gives two 8-bit counters. The low byte runs on run bit 0 and sets flag 0. The high byte counts machine cycles on run bit 1 and sets flag 1.
- R7: While channel 0 is in mode 3, channel 1 counts whatever its run bit says and never sets flag 1. Channel 1 set to mode 3 holds its count.
- R8: With the count-source bit set, the channel advances once for each machine cycle in which the pin sample is 0 and the previous machine cycle's sample was 1. A pin held at one level adds nothing.
- R9: A channel whose run bit is 0 holds its count bytes.
- R10: A flag stays set until a `flag_clr` pulse or a control write with that flag bit 0 clears it. An overflow in the same clock as a clear leaves the flag set. A control write with the flag bit 1 sets the flag.
- R11: A count-byte write in the same clock as a counting step stores the written value, and that step is lost.
- R12: `baud_strobe` is high for exactly one clock, the clock after each channel 1 overflow.
- R13: Register map. Address 0 is control: bit0 run0, bit1 run1, bit2 flag0, bit3 flag1. Address 1 is the mode register: [1:0] mode0, [2] source0, [4:3] mode1, [5] source1, where a source bit of 1 selects the pin. Addresses 2 to 5 are low0, high0, low1 and high1. Reads of unused bits give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ev_pin | input | 2 | Event pins, one per channel, synchronous to `clk` |
| flag_clr | input | 2 | Flag clear pulses, one per channel |
| irq_req | output | 2 | Interrupt requests, equal to the flags |
| baud_strobe | output | 1 | One-clock pulse per channel 1 overflow |

## Verification
The bench goes after the wrap points of each mode:
- **13-bit mode.** The bench checks the carry out of bit 4 and that bits [7:5] of the low byte are untouched. A design that carried out of bit 7 would leave the high byte late and change the low byte's upper bits.
- **Reload mode.** It checks the reload value. A design that wrapped the low byte to zero would miss it.
- **Split mode.** It checks that channel 1's overflow stays out of flag 1. A wrong design would raise a spurious interrupt.
- **Write timing.** It lines a byte write up with a machine-cycle tick. A design that let the increment win would show the written value plus one.
- **Pin edges and flags.** It drives pin levels that are held for a long time, to expose level counting instead of edge counting. It checks that the flag holds across idle time and clears only on the clear pulse or a control write.

Long constrained-random runs then compare every register against a cycle model.

// File: rtl/tmr_pkg.sv
// Package: tmr_pkg
// Shared widths, register addresses and the mode encoding for the dual
// timer/counter. Assumes an 8-bit register port and two channels.
package tmr_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int N_CH    = 2;
    localparam int LO13_W  = 5;   // low-byte bits used by the 13-bit mode
    localparam int MFLD_W  = 3;   // mode field (2) plus source bit (1)

    typedef enum logic [1:0] {
        MODE_13B    = 2'd0,
        MODE_16B    = 2'd1,
        MODE_RELOAD = 2'd2,
        MODE_SPLIT  = 2'd3
    } tmr_mode_e;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
    localparam int                A_BYTE0 = 2;  // lo0, hi0, lo1, hi1 follow
endpackage

// File: rtl/tmr_mc_gen.sv
// Module: tmr_mc_gen
// Divides the clock into machine cycles: raises tick for one clock every
// DIV clocks. Assumes DIV >= 2 so that ticks never fall on adjacent clocks.
module tmr_mc_gen #(
    parameter int DIV = 12
)(
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt;

    // Free-running modulo-DIV counter.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + ONE;
    end

    assign tick = (cnt == LAST);

    // R2: machine-cycle ticks are isolated single-clock pulses
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tmr_edge_sample.sv
// Module: tmr_edge_sample
// Samples one event pin once per machine cycle and flags a 1-to-0 change
// between consecutive samples. Assumes the pin is already synchronous to clk.
module tmr_edge_sample (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic fall
);
    logic samp_q;

    // Hold the pin level seen at the previous machine-cycle tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    samp_q <= 1'b0;
        else if (tick) samp_q <= pin;
    end

    assign fall = tick & samp_q & ~pin;

    // R8: a pin held low for two ticks cannot produce an edge on the second
    assert_low_no_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pin) |=> !fall until_with tick);
endmodule

// File: rtl/tmr_channel.sv
// Module: tmr_channel
// One timer/counter channel: a low and a high byte advanced by step_lo (and
// step_hi in split mode) according to the selected mode. Byte writes take
// priority over a step in the same clock. SPLIT_OK=0 makes the split mode
// hold the count, which is how channel 1 behaves in that mode.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter bit SPLIT_OK = 1'b1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_mode_e         mode,
    input  logic              step_lo,
    input  logic              step_hi,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi,
    output logic              ovf_main,
    output logic              ovf_hi
);
    localparam int W13 = BYTE_W + LO13_W;
    localparam logic [W13:0]      ONE13 = (W13+1)'(1);
    localparam logic [2*BYTE_W:0] ONE16 = (2*BYTE_W+1)'(1);
    localparam logic [BYTE_W-1:0] ONE8  = BYTE_W'(1);

    logic [W13:0]      sum13;
    logic [2*BYTE_W:0] sum16;
    logic [BYTE_W-1:0] lo_nxt, hi_nxt;

    // Next count value and overflow pulses for the active mode.
    always_comb begin
        sum13    = {1'b0, hi, lo[LO13_W-1:0]} + ONE13;
        sum16    = {1'b0, hi, lo} + ONE16;
        lo_nxt   = lo;
        hi_nxt   = hi;
        ovf_main = 1'b0;
        ovf_hi   = 1'b0;
        case (mode)
            MODE_13B: if (step_lo) begin
                hi_nxt   = sum13[LO13_W +: BYTE_W];
                lo_nxt   = {lo[BYTE_W-1:LO13_W], sum13[LO13_W-1:0]};
                ovf_main = sum13[W13];
            end
            MODE_16B: if (step_lo) begin
                {hi_nxt, lo_nxt} = sum16[2*BYTE_W-1:0];
                ovf_main         = sum16[2*BYTE_W];
            end
            MODE_RELOAD: if (step_lo) begin
                ovf_main = (lo == '1);
                lo_nxt   = ovf_main ? hi : lo + ONE8;
            end
            default: if (SPLIT_OK) begin
                if (step_lo) begin
                    ovf_main = (lo == '1);
                    lo_nxt   = lo + ONE8;
                end
                if (step_hi) begin
                    ovf_hi = (hi == '1);
                    hi_nxt = hi + ONE8;
                end
            end
        endcase
    end

    // Count bytes: a register write replaces the computed next value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= wr_lo ? wdata : lo_nxt;
            hi <= wr_hi ? wdata : hi_nxt;
        end
    end

    // R9: with no step and no write both bytes hold
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_lo && !step_hi && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi)));

    // R5: an overflowing low byte in reload mode takes the old high byte
    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RELOAD && step_lo && lo == '1 && !wr_lo) |=> (lo == $past(hi)));

    // R3: the 13-bit mode never alters the upper low-byte bits
    assert_upper_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_13B && !wr_lo) |=> (lo[BYTE_W-1:LO13_W] == $past(lo[BYTE_W-1:LO13_W])));

    // R11: a write in the same clock as a step stores the written value
    assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && step_lo) |=> (lo == $past(wdata)));
endmodule

// File: rtl/dual_timer_counter.sv
// Module: dual_timer_counter (top)
// Two timer/counter channels with a shared register port, sticky overflow
// flags driving interrupt requests, and a channel 1 overflow strobe.
// Assumes ev_pin and flag_clr are synchronous to clk and MC_DIV >= 2.
module dual_timer_counter
    import tmr_pkg::*;
#(
    parameter int MC_DIV = 12
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [N_CH-1:0]   ev_pin,
    input  logic [N_CH-1:0]   flag_clr,
    output logic [N_CH-1:0]   irq_req,
    output logic              baud_strobe
);
    logic              mc_tick;
    logic [N_CH-1:0]   run, ext, flag, flag_set, fall;
    logic [N_CH-1:0]   step_lo, step_hi, wr_lo, wr_hi, ovf_main, ovf_hi;
    tmr_mode_e         mode [N_CH];
    logic [BYTE_W-1:0] lo_q [N_CH];
    logic [BYTE_W-1:0] hi_q [N_CH];
    logic              split, ctl_wr, mode_wr;
    logic              wdata_unused;

    assign split        = (mode[0] == MODE_SPLIT);
    assign ctl_wr       = bus_wr && (bus_addr == A_CTRL);
    assign mode_wr      = bus_wr && (bus_addr == A_MODE);
    assign wdata_unused = ^{bus_wdata[BYTE_W-1:N_CH*MFLD_W], ovf_hi[1]};

    tmr_mc_gen #(.DIV(MC_DIV)) u_mc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (mc_tick)
    );

    // Step enables: channel 1's run bit serves channel 0's high half when split.
    assign step_lo[0] = mc_tick & run[0] & (~ext[0] | fall[0]);
    assign step_hi[0] = mc_tick & run[1];
    assign step_lo[1] = mc_tick & (split | run[1]) & (~ext[1] | fall[1]);
    assign step_hi[1] = 1'b0;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        assign wr_lo[g] = bus_wr && (bus_addr == ADDR_W'(A_BYTE0 + 2*g));
        assign wr_hi[g] = bus_wr && (bus_addr == ADDR_W'(A_BYTE0 + 2*g + 1));

        tmr_edge_sample u_smp (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (mc_tick),
            .pin   (ev_pin[g]),
            .fall  (fall[g])
        );

        tmr_channel #(.SPLIT_OK(g == 0)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (mode[g]),
            .step_lo  (step_lo[g]),
            .step_hi  (step_hi[g]),
            .wr_lo    (wr_lo[g]),
            .wr_hi    (wr_hi[g]),
            .wdata    (bus_wdata),
            .lo       (lo_q[g]),
            .hi       (hi_q[g]),
            .ovf_main (ovf_main[g]),
            .ovf_hi   (ovf_hi[g])
        );

        // R10: a set flag survives a clock with no clear of either kind
        assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[g] && !flag_clr[g] && !ctl_wr) |=> flag[g]);
    end

    // Control and mode fields written from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= '0;
            ext <= '0;
            for (int i = 0; i < N_CH; i++) mode[i] <= MODE_13B;
        end else begin
            if (ctl_wr) run <= bus_wdata[N_CH-1:0];
            if (mode_wr) begin
                for (int i = 0; i < N_CH; i++) begin
                    mode[i] <= tmr_mode_e'(bus_wdata[i*MFLD_W +: 2]);
                    ext[i]  <= bus_wdata[i*MFLD_W + 2];
                end
            end
        end
    end

    // Flag sources: in split mode flag 1 follows channel 0's high half.
    assign flag_set[0] = ovf_main[0];
    assign flag_set[1] = split ? ovf_hi[0] : ovf_main[1];

    // Sticky flags: overflow sets, otherwise control write or clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= '0;
        else begin
            for (int i = 0; i < N_CH; i++)
                flag[i] <= flag_set[i] |
                           (ctl_wr ? bus_wdata[N_CH+i] : (flag[i] & ~flag_clr[i]));
        end
    end

    // Channel 1 overflow strobe, one clock wide.
    always_ff @(posedge clk) begin
        if (!rst_n) baud_strobe <= 1'b0;
        else        baud_strobe <= ovf_main[1];
    end

    assign irq_req = flag;

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: bus_rdata[2*N_CH-1:0] = {flag, run};
            A_MODE: for (int i = 0; i < N_CH; i++)
                        bus_rdata[i*MFLD_W +: MFLD_W] = {ext[i], mode[i]};
            default: for (int i = 0; i < N_CH; i++) begin
                if (bus_addr == ADDR_W'(A_BYTE0 + 2*i))     bus_rdata = lo_q[i];
                if (bus_addr == ADDR_W'(A_BYTE0 + 2*i + 1)) bus_rdata = hi_q[i];
            end
        endcase
    end

    // R7: while split, channel 1 cannot raise flag 1
    assert_split_noflag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (split && !flag[1] && !ovf_hi[0] && !ctl_wr) |=> !flag[1]);

    // R6: the split high half stops when run bit 1 is clear
    assert_split_hi_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (split && !run[1] && !wr_hi[0]) |=> $stable(hi_q[0]));

    // R12: the overflow strobe is a single-clock pulse
    assert_strobe_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        baud_strobe |=> !baud_strobe);
endmodule

// File: tb/dual_timer_counter_tb.sv
// Bench: dual_timer_counter_tb_top
// Directed corner cases plus seeded random traffic, checked against a
// cycle model built from the requirements.
module dual_timer_counter_tb_top;
    localparam int PERIOD = 20;
    localparam int DIV    = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] ev_pin = '0;
    logic [1:0] flag_clr = '0;
    logic [1:0] irq_req;
    logic       baud_strobe;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    bit mon_on = 0;

    dual_timer_counter #(.MC_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_pin(ev_pin),
        .flag_clr(flag_clr), .irq_req(irq_req), .baud_strobe(baud_strobe)
    );

    always #(PERIOD/2) clk = ~clk;

    // ---------------- reference model ----------------
    logic [7:0] m_lo [2];
    logic [7:0] m_hi [2];
    bit   [1:0] m_mode [2];
    bit         m_run [2], m_flag [2], m_ext [2], m_samp [2];
    bit         m_strobe;
    int         m_pre;

    task automatic adv(input int c, input bit s, input bit sh, output bit ov, output bit ovh);
        logic [13:0] t13;
        logic [16:0] t16;
        ov = 0; ovh = 0;
        case (m_mode[c])
            2'd0: if (s) begin
                t13 = {1'b0, m_hi[c], m_lo[c][4:0]} + 14'd1;
                ov = t13[13]; m_hi[c] = t13[12:5]; m_lo[c][4:0] = t13[4:0];
            end
            2'd1: if (s) begin
                t16 = {1'b0, m_hi[c], m_lo[c]} + 17'd1;
                ov = t16[16]; m_hi[c] = t16[15:8]; m_lo[c] = t16[7:0];
            end
            2'd2: if (s) begin
                if (m_lo[c] == 8'hFF) begin m_lo[c] = m_hi[c]; ov = 1; end
                else m_lo[c] = m_lo[c] + 8'd1;
            end
            default: if (c == 0) begin
                if (s)  begin ov  = (m_lo[0] == 8'hFF); m_lo[0] = m_lo[0] + 8'd1; end
                if (sh) begin ovh = (m_hi[0] == 8'hFF); m_hi[0] = m_hi[0] + 8'd1; end
            end
        endcase
    endtask

    always @(posedge clk) begin
        bit tick, split, ctl;
        bit fall [2];
        bit s0, sh, s1, o0, oh, o1, unused_h;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_lo[i] = 0; m_hi[i] = 0; m_mode[i] = 0;
                m_run[i] = 0; m_flag[i] = 0; m_ext[i] = 0; m_samp[i] = 0;
            end
            m_strobe = 0; m_pre = 0;
        end else begin
            tick  = (m_pre == DIV-1);
            m_pre = tick ? 0 : m_pre + 1;
            for (int i = 0; i < 2; i++) begin
                fall[i] = tick && m_samp[i] && !ev_pin[i];
                if (tick) m_samp[i] = ev_pin[i];
            end
            split = (m_mode[0] == 2'd3);
            s0 = tick && m_run[0] && (!m_ext[0] || fall[0]);
            sh = tick && m_run[1];
            s1 = tick && (split || m_run[1]) && (!m_ext[1] || fall[1]);
            adv(0, s0, sh, o0, oh);
            adv(1, s1, 1'b0, o1, unused_h);
            ctl = bus_wr && bus_addr == 0;
            if (bus_wr) case (bus_addr)
                3'd0: begin m_run[0] = bus_wdata[0]; m_run[1] = bus_wdata[1]; end
                3'd1: begin
                    m_mode[0] = bus_wdata[1:0]; m_ext[0] = bus_wdata[2];
                    m_mode[1] = bus_wdata[4:3]; m_ext[1] = bus_wdata[5];
                end
                3'd2: m_lo[0] = bus_wdata;
                3'd3: m_hi[0] = bus_wdata;
                3'd4: m_lo[1] = bus_wdata;
                3'd5: m_hi[1] = bus_wdata;
                default: ;
            endcase
            for (int i = 0; i < 2; i++)
                m_flag[i] = (ctl ? bus_wdata[2+i] : (m_flag[i] && !flag_clr[i]));
            if (o0) m_flag[0] = 1;
            if (split ? oh : o1) m_flag[1] = 1;
            m_strobe = o1;
        end
    end

    function automatic logic [7:0] model_reg(input int a);
        case (a)
            0: return {4'd0, m_flag[1], m_flag[0], m_run[1], m_run[0]};
            1: return {2'd0, m_ext[1], m_mode[1], m_ext[0], m_mode[0]};
            2: return m_lo[0];
            3: return m_hi[0];
            4: return m_lo[1];
            5: return m_hi[1];
            default: return 8'd0;
        endcase
    endfunction

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        bus_addr = a[2:0];
        #1;
        v = bus_rdata;
    endtask

    task automatic check_all(input string tag);
        logic [7:0] v;
        for (int a = 0; a < 7; a++) begin
            rd(a, v);
            chk(tag, v, model_reg(a));
        end
        chk(tag, irq_req, {m_flag[1], m_flag[0]});
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a[2:0]; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic wait_irq(input int b, input int maxc, output bit ok);
        ok = 0;
        for (int i = 0; i < maxc && !ok; i++) begin
            @(negedge clk);
            if (irq_req[b]) ok = 1;
        end
    endtask

    task automatic sync_tick();
        logic [7:0] v0, v1;
        rd(2, v0);
        for (int i = 0; i < 3*DIV; i++) begin
            @(negedge clk);
            rd(2, v1);
            if (v1 != v0) break;
        end
    endtask

    // Strobe compared against the model on every clock (R12).
    always @(negedge clk) if (mon_on && rst_n) chk("R12 strobe", baud_strobe, m_strobe);

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] v, w, a0, a1;
        bit ok;
        int seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1;
        mon_on = 1;
        @(negedge clk);
        // R1: reset state
        check_all("R1 reset");
        chk("R1 strobe", baud_strobe, 1'b0);

        // R2 / R4: 16-bit timer, per-tick increment
        wr(1, 8'h01); wr(3, 8'h12); wr(2, 8'hF0); wr(0, 8'h01);
        sync_tick();
        rd(2, v);
        repeat (DIV-1) @(negedge clk);
        rd(2, w); chk("R2 no step before tick", w, v);
        @(negedge clk);
        rd(2, w); chk("R2 one step per machine cycle", w, v + 8'd1);
        wr(0, 8'h00); wr(2, 8'hFF); wr(3, 8'h12); wr(0, 8'h01);
        sync_tick();
        rd(2, a0); rd(3, a1);
        chk("R4 16-bit carry low", a0, 8'h00);
        chk("R4 16-bit carry high", a1, 8'h13);
        check_all("R4 model");

        // R11: write aligned with a tick wins
        sync_tick();
        repeat (DIV-2) @(negedge clk);
        wr(2, 8'h40);
        rd(2, v); chk("R11 write beats step", v, 8'h40);
        repeat (DIV) @(negedge clk);
        rd(2, v); chk("R11 next step", v, 8'h41);

        // R3: 13-bit wrap
        wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'hFE); wr(3, 8'hFF); wr(0, 8'h01);
        wait_irq(0, 5*DIV, ok);
        chk("R3 flag raised", ok, 1'b1);
        rd(2, a0); rd(3, a1);
        chk("R3 low wraps, upper bits kept", a0, 8'hE0);
        chk("R3 high wraps", a1, 8'h00);
        check_all("R3 model");

        // R5: reload
        wr(0, 8'h00); wr(1, 8'h02); wr(3, 8'h9C); wr(2, 8'hFE); wr(0, 8'h01);
        wait_irq(0, 5*DIV, ok);
        chk("R5 flag raised", ok, 1'b1);
        rd(2, a0); chk("R5 reload value", a0, 8'h9C);

        // R10: sticky flag, clear pulse, control write
        wr(0, 8'h04);
        repeat (3*DIV) @(negedge clk);
        chk("R10 flag holds", irq_req[0], 1'b1);
        @(negedge clk); flag_clr = 2'b01; @(negedge clk); flag_clr = 2'b00;
        chk("R10 clear pulse", irq_req[0], 1'b0);
        wr(0, 8'h04); chk("R10 control write sets", irq_req[0], 1'b1);
        wr(0, 8'h00); chk("R10 control write clears", irq_req[0], 1'b0);

        // R6 / R7 / R12: split mode, channel 1 as strobe source
        wr(1, 8'h0B); wr(4, 8'hFE); wr(5, 8'hFF); wr(3, 8'hF0); wr(2, 8'h55); wr(0, 8'h02);
        ok = 0;
        for (int i = 0; i < 4*DIV && !ok; i++) begin
            @(negedge clk);
            if (baud_strobe) ok = 1;
        end
        chk("R12 strobe seen", ok, 1'b1);
        chk("R7 no flag from channel 1", irq_req[1], 1'b0);
        @(negedge clk);
        chk("R12 strobe one clock", baud_strobe, 1'b0);
        wait_irq(1, 20*DIV, ok);
        chk("R6 high half sets flag 1", ok, 1'b1);
        rd(3, a1); chk("R6 high half wrapped", a1, 8'h00);
        rd(2, a0); chk("R6 low half idle without run0", a0, 8'h55);
        wr(0, 8'h00);
        rd(4, a0); rd(5, a1); rd(3, v);
        repeat (2*DIV) @(negedge clk);
        rd(4, w); rd(5, bus_wdata);
        chk("R7 channel 1 runs without run1", {bus_wdata, w}, {a1, a0} + 16'd2);
        rd(3, w); chk("R6 high half stopped", w, v);
        wr(1, 8'h19); wr(0, 8'h03);
        rd(4, v);
        repeat (3*DIV) @(negedge clk);
        rd(4, w); chk("R7 channel 1 split mode holds", w, v);

        // R8: counting pin falling edges
        wr(0, 8'h00); wr(1, 8'h05); wr(2, 8'h00); wr(3, 8'h00);
        ev_pin[0] = 1; repeat (3*DIV) @(negedge clk);
        wr(0, 8'h01);
        for (int k = 0; k < 4; k++) begin
            ev_pin[0] = 0; repeat (3*DIV) @(negedge clk);
            ev_pin[0] = 1; repeat (3*DIV) @(negedge clk);
        end
        rd(2, v); chk("R8 one count per falling edge", v, 8'h04);
        ev_pin[0] = 0; repeat (5*DIV) @(negedge clk);
        rd(2, v); chk("R8 held level adds nothing", v, 8'h05);

        // R9: stop holds the count
        wr(1, 8'h01); wr(0, 8'h01);
        repeat (3*DIV) @(negedge clk);
        wr(0, 8'h00);
        rd(2, a0); rd(3, a1);
        repeat (4*DIV) @(negedge clk);
        rd(2, v); chk("R9 low held", v, a0);
        rd(3, v); chk("R9 high held", v, a1);
        check_all("R13 register map");

        // Constrained random traffic against the model (R4 and the rest)
        for (int it = 0; it < 1500; it++) begin
            int op, a;
            logic [7:0] d;
            op = $urandom_range(0, 9);
            a  = $urandom_range(0, 5);
            case ($urandom_range(0, 3))
                0: d = 8'hFF;
                1: d = 8'hFE;
                2: d = 8'h1F;
                default: d = 8'($urandom);
            endcase
            if (op < 5) wr(a, d);
            else if (op == 5) begin
                @(negedge clk); flag_clr = 2'($urandom); @(negedge clk); flag_clr = 0;
            end
            if ($urandom_range(0, 1) == 1) ev_pin = 2'($urandom);
            repeat ($urandom_range(0, 2*DIV)) @(negedge clk);
            @(negedge clk);
            check_all("R4 random model");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule